// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block sends data words out of a single serial pin. An external master supplies the bit clock, so the block needs no internal baud generator. It only follows the master's clock edges, which it brings into its own system clock domain through a two-flop synchroniser. Frames carry 8 data bits, or 9 when the ninth-bit mode is on. Bits leave least significant first. A new bit is presented after each falling edge of the external clock, and the master samples it on the rising edge.

The host writes a word into a one-word holding register. If the shifter is idle, the word moves on to it at once. If the shifter is busy, the word waits in the holding register. It is handed over on the same system clock edge that ends the current frame. Two status outputs are visible to the host:

- a buffer-empty flag, which drops while a word waits in the holding register;
- a shifter-empty status.

An interrupt request is raised while its enable is set and the holding register is free. The transmitter runs only when all of the following hold: the port is enabled, synchronous mode is selected, the external clock source is selected, transmit is enabled, and both receive enables are off. Dropping any of these conditions returns the block to its reset state.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, shift_empty reads 1, buf_empty reads 0, irq reads 0 and sdo reads 1 (idle high).
- R2: The transmitter is active only when port_en=1, sync_mode=1, clk_src_int=0, tx_en=1, rx_cont_en=0 and rx_single_en=0. While inactive, the holding register and the shifter are empty, shift_empty=1, buf_empty=0, and writes are ignored.
- R3: A word written while the shifter and holding register are empty enters the shifter on the second rising system clock edge after the write strobe is sampled. sdo then shows its bit 0, and shift_empty drops to 0.
- R4: Bits go out LSB first. sdo changes only as a result of a falling edge of ext_sck, seen after two synchroniser flops and one edge-detect flop. sdo is 1 whenever the shifter is empty.
- R5: A word written while the shifter is busy waits in the holding register. buf_empty stays 0 until that word moves into the shifter.
- R6: The falling ext_sck edge that ends a frame moves a waiting word into the shifter on the same system clock edge. At that moment buf_empty becomes 1 and shift_empty stays 0.
- R7: When nine_bit_mode=1 at the write, the frame is 9 bits and the ninth bit sent is the value of bit9_val at that write. When nine_bit_mode=0 the frame is 8 bits and bit9_val has no effect.
- R8: irq equals int_en AND buf_empty.
- R9: shift_empty is 1 exactly when no word is in the shifter. After the last bit of a frame with no waiting word, it returns to 1.
- R10: Clearing tx_en or port_en in the middle of a frame empties the shifter and the holding register. Re-enabling resumes with no trace of the aborted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sck | input | 1 | Shift clock from the external master |
| clk_src_int | input | 1 | Clock source select; 0 selects the external clock |
| sync_mode | input | 1 | Synchronous mode select |
| port_en | input | 1 | Serial port enable |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 to transmit |
| rx_single_en | input | 1 | Single receive enable; must be 0 to transmit |
| tx_en | input | 1 | Transmit enable |
| nine_bit_mode | input | 1 | Selects 9-bit frames |
| bit9_val | input | 1 | Ninth data bit, captured with the word |
| int_en | input | 1 | Interrupt enable |
| wr_stb | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | DATA_W | Data word to write |
| sdo | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding register free flag |
| shift_empty | output | 1 | Shifter empty status |
| irq | output | 1 | Interrupt / wake request |

## Verification
A word is first sent into an idle shifter, which shows both the immediate load and the LSB-first order on the master's rising edges. A second word is then written behind an active frame. This separates a buf_empty that waits for the hand-off from one that rises too early, and it shows whether the two frames run back to back. Frames are sent in 9-bit mode with the ninth bit at both 1 and 0, and in 8-bit mode with bit9_val set, to tell a ninth bit carried in the frame from one that leaks into an 8-bit frame. Writes are made under each disqualifying configuration, and the transmitter is disabled mid-frame. These cases expose any state that survives, or any write that is taken, while the port is inactive.

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_sck,
  input  logic              clk_src_int,
  input  logic              sync_mode,
  input  logic              port_en,
  input  logic              rx_cont_en,
  input  logic              rx_single_en,
  input  logic              tx_en,
  input  logic              nine_bit_mode,
  input  logic              bit9_val,
  input  logic              int_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              buf_empty,
  output logic              shift_empty,
  output logic              irq
);
  localparam int FW = DATA_W + 1;
  localparam int CW = $clog2(FW + 1);

  logic active;
  logic sck_s1, sck_s2, sck_d;
  logic fall;
  logic [FW-1:0] hold_q, sh_q;
  logic [CW-1:0] hold_len, bits_left;
  logic hold_full, sh_full;
  logic frame_end, load;

  assign active    = port_en & sync_mode & ~clk_src_int & tx_en & ~rx_cont_en & ~rx_single_en;
  assign fall      = sck_d & ~sck_s2;
  assign frame_end = sh_full & fall & (bits_left == CW'(1));
  assign load      = hold_full & (~sh_full | frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s1 <= 1'b0;
      sck_s2 <= 1'b0;
      sck_d  <= 1'b0;
    end else begin
      sck_s1 <= ext_sck;
      sck_s2 <= sck_s1;
      sck_d  <= sck_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_len  <= '0;
      hold_full <= 1'b0;
      sh_q      <= '0;
      bits_left <= '0;
      sh_full   <= 1'b0;
    end else if (!active) begin
      hold_full <= 1'b0;
      sh_full   <= 1'b0;
      bits_left <= '0;
    end else begin
      if (load) begin
        sh_q      <= hold_q;
        bits_left <= hold_len;
        sh_full   <= 1'b1;
      end else if (frame_end) begin
        sh_full   <= 1'b0;
        bits_left <= '0;
      end else if (sh_full && fall) begin
        sh_q      <= sh_q >> 1;
        bits_left <= bits_left - CW'(1);
      end

      if (wr_stb) begin
        hold_full <= 1'b1;
        hold_q    <= {bit9_val & nine_bit_mode, wr_data};
        hold_len  <= nine_bit_mode ? CW'(FW) : CW'(DATA_W);
      end else if (load) begin
        hold_full <= 1'b0;
      end
    end
  end

  assign sdo         = sh_full ? sh_q[0] : 1'b1;
  assign shift_empty = ~sh_full;
  assign buf_empty   = active & ~hold_full;
  assign irq         = int_en & buf_empty;
endmodule

// File: rtl/sync_slave_tx_chk.sv
module sync_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic fall,
  input logic sdo,
  input logic buf_empty,
  input logic shift_empty
);
  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> shift_empty);

  p_sdo_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> sdo);

  p_sdo_moves_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_empty && $past(!shift_empty) && !$stable(sdo)) |-> $past(fall));

  p_hold_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !buf_empty && !shift_empty && !fall) |=> (!buf_empty || !active));

  p_rise_on_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $rose(buf_empty)) |-> !shift_empty);
endmodule

bind sync_slave_tx sync_slave_tx_chk u_chk (.*);

// File: tb/tb_sync_slave_tx.sv
`timescale 1ns/1ps
module tb_sync_slave_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sck = 1'b0;
  logic clk_src_int = 1'b0, sync_mode = 1'b0, port_en = 1'b0;
  logic rx_cont_en = 1'b0, rx_single_en = 1'b0, tx_en = 1'b0;
  logic nine_bit_mode = 1'b0, bit9_val = 1'b0, int_en = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic sdo, buf_empty, shift_empty, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sync_slave_tx dut (.*);

  // reference model
  bit mq[$];
  bit rxq[$];
  bit [8:0] m_hold;
  int m_hold_len = 0;
  bit m_hold_full = 0;
  bit h1 = 0, h2 = 0, h3 = 0;

  function automatic bit cfg_ok();
    return port_en && sync_mode && !clk_src_int && tx_en && !rx_cont_en && !rx_single_en;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit f, ld;
    f = h3 && !h2;
    h3 = h2; h2 = h1; h1 = ext_sck;
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0;
      mq.delete(); m_hold_full = 0;
    end else if (!cfg_ok()) begin
      mq.delete(); m_hold_full = 0;
    end else begin
      ld = 0;
      if (mq.size() > 0 && f) begin
        void'(mq.pop_front());
        if (mq.size() == 0 && m_hold_full) ld = 1;
      end else if (mq.size() == 0 && m_hold_full) ld = 1;
      if (ld) begin
        for (int i = 0; i < m_hold_len; i++) mq.push_back(m_hold[i]);
        m_hold_full = 0;
      end
      if (wr_stb) begin
        m_hold = {nine_bit_mode & bit9_val, wr_data};
        m_hold_len = nine_bit_mode ? 9 : 8;
        m_hold_full = 1;
      end
    end
    #5;
    begin
      bit be;
      be = cfg_ok() && !m_hold_full;
      check("R4", "sdo", sdo, mq.size() > 0 ? mq[0] : 1);
      check("R9", "shift_empty", shift_empty, mq.size() == 0);
      check("R5", "buf_empty", buf_empty, be);
      check("R8", "irq", irq, int_en && be);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(bit [7:0] d);
    @(negedge clk);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!shift_empty) rxq.push_back(sdo);
      ext_sck = 1'b1;
      cyc(8);
      ext_sck = 1'b0;
      cyc(8);
    end
  endtask

  task automatic expect_frame(string tag, int n, int val);
    int got = 0;
    check(tag, "bits received", rxq.size(), n);
    for (int i = 0; i < n && rxq.size() > 0; i++) got |= int'(rxq.pop_front()) << i;
    check(tag, "frame value", got, val);
  endtask

  task automatic enable_port();
    @(negedge clk);
    port_en = 1; sync_mode = 1; clk_src_int = 0; tx_en = 1;
    rx_cont_en = 0; rx_single_en = 0;
  endtask

  initial begin
    cyc(3);
    check("R1", "shift_empty", shift_empty, 1);
    check("R1", "buf_empty", buf_empty, 0);
    check("R1", "irq", irq, 0);
    check("R1", "sdo", sdo, 1);
    rst_n = 1'b1;
    cyc(2);
    check("R1", "shift_empty after release", shift_empty, 1);

    enable_port();
    cyc(1);
    check("R2", "buf_empty once active", buf_empty, 1);

    // R3: load into idle shifter, R4 LSB first, R7 bit9 ignored in 8-bit
    bit9_val = 1;
    rxq.delete();
    write_word(8'hA5);
    cyc(1);
    check("R3", "shift_empty after load", shift_empty, 0);
    check("R3", "sdo shows bit0", sdo, 1);
    pulses(8);
    cyc(2);
    expect_frame("R4", 8, 'hA5);
    check("R9", "shift_empty after frame", shift_empty, 1);
    pulses(1);
    check("R7", "no ninth bit in 8-bit mode", rxq.size(), 0);
    bit9_val = 0;

    // R5/R6: second word waits, hand-off on frame end
    rxq.delete();
    write_word(8'h3C);
    cyc(2);
    write_word(8'hC3);
    pulses(3);
    check("R5", "buf_empty while word waits", buf_empty, 0);
    pulses(5);
    check("R6", "buf_empty after hand-off", buf_empty, 1);
    check("R6", "shift_empty after hand-off", shift_empty, 0);
    pulses(8);
    cyc(2);
    expect_frame("R6", 16, 'hC33C);
    check("R9", "shift_empty after two frames", shift_empty, 1);

    // R7: 9-bit frames
    nine_bit_mode = 1; bit9_val = 1;
    rxq.delete();
    write_word(8'h55);
    pulses(9);
    expect_frame("R7", 9, 'h155);
    bit9_val = 0;
    write_word(8'hF0);
    pulses(9);
    expect_frame("R7", 9, 'h0F0);
    nine_bit_mode = 0;

    // R8: interrupt
    int_en = 1;
    cyc(2);
    check("R8", "irq while buffer free", irq, 1);
    write_word(8'h81);
    write_word(8'h18);
    check("R8", "irq while word waits", irq, 0);
    int_en = 0;
    cyc(1);
    check("R8", "irq masked", irq, 0);

    // R10: disable mid-frame
    pulses(3);
    @(negedge clk); tx_en = 0;
    cyc(1);
    check("R10", "shift_empty after disable", shift_empty, 1);
    check("R10", "buf_empty after disable", buf_empty, 0);
    check("R10", "sdo after disable", sdo, 1);
    tx_en = 1;
    cyc(3);
    check("R10", "no leftover word", shift_empty, 1);
    check("R10", "holding free on re-enable", buf_empty, 1);
    @(negedge clk); port_en = 0;
    cyc(1);
    port_en = 1;
    cyc(2);
    check("R10", "port_en toggle keeps empty", shift_empty, 1);

    // R2: disqualifying configurations ignore writes
    @(negedge clk); rx_cont_en = 1;
    write_word(8'h99);
    cyc(3);
    check("R2", "write ignored with receive on", shift_empty, 1);
    rx_cont_en = 0;
    cyc(2);
    check("R2", "no late load after receive off", shift_empty, 1);
    @(negedge clk); clk_src_int = 1;
    write_word(8'h66);
    cyc(3);
    check("R2", "write ignored with internal clock", shift_empty, 1);
    clk_src_int = 0;
    @(negedge clk); rx_single_en = 1;
    write_word(8'h77);
    cyc(3);
    check("R2", "write ignored with single receive", shift_empty, 1);
    rx_single_en = 0;
    cyc(3);
    check("R2", "still empty after re-qualify", shift_empty, 1);

    cyc(4);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule